// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the directory engine at one home node of a small distributed shared memory machine. Each memory block has one home node, chosen by the low bits of its block address. For every block homed at this node, the controller keeps a directory entry: a two-bit state and a one-bit-per-node sharer vector. Remote and local caches send read, read-exclusive and upgrade requests over a valid/ready message port. The controller answers over a second valid/ready port. It sends invalidations, interventions and replies with or without data only to the nodes that the sharer vector names, and never broadcasts.

The controller has one transaction open at a time. While a transaction waits for invalidation acknowledgements or for an owner's flush, the block's entry holds the busy code and the request port refuses new requests. Only the acknowledgement or flush that the open transaction expects is taken in. After reset, a sweep clears every directory entry to uncached before the first request is accepted. Requests whose home bits name another node are consumed, flagged on an error pulse and given no answer.

Directory state codes: 00 uncached, 01 shared, 10 exclusive, 11 busy.

Top module: `dir_home_ctrl`

## Requirements
- R1: A read, read-exclusive or upgrade request whose block bits [1:0] differ from HOME_ID (default 1) is accepted. It raises `home_err_o` for exactly one cycle and produces no outgoing message.
- R2: A read to an uncached or shared block gets a data reply (out kind 2) to the requester, and the requester is added to the sharer vector.
- R3: A read-exclusive or upgrade to a block with other holders sends one invalidation (out kind 0) to each holder except the requester, lowest node number first, and to no other node.
- R4: The final reply of a read-exclusive or upgrade that needed invalidations is sent only after one acknowledgement (in kind 3, same block) has arrived for every invalidation sent.
- R5: A read-exclusive always gets a data reply. An upgrade from a node that holds a copy gets a reply without data (out kind 3), and an upgrade from a node without a copy gets a data reply. In all three cases the block ends exclusive to the requester. When the upgrading node is the only holder, the reply goes out with no invalidation.
- R6: A read to a block held exclusive by another node sends an intervention (out kind 1) to the owner. When the owner's flush (in kind 4, same block, from the owner) arrives, a data reply goes to the requester, and both nodes become sharers.
- R7: While a transaction is open, `req_ready_o` stays low for read, read-exclusive and upgrade requests. They are held until the transaction ends.
- R8: After reset: `msg_valid_o` and `home_err_o` are low, every block is uncached, and `req_ready_o` stays low during the clearing sweep of 2^(BLK_W-log2 NODES) cycles.
- R9: While `msg_valid_o` is high and `msg_ready_i` is low, the outgoing message stays valid and its kind, destination and block do not change.
- R10: An acknowledgement or flush that arrives with no transaction open is consumed and has no effect on any output or directory entry.
- R11: Request kind codes are read 0, read-exclusive 1 and upgrade 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Incoming message valid |
| req_ready_o | output | 1 | Incoming message accepted when high with valid |
| req_kind_i | input | 3 | 0 read, 1 read-exclusive, 2 upgrade, 3 invalidation ack, 4 flush |
| req_src_i | input | 2 | Sending node |
| req_blk_i | input | 6 | Block address; bits [1:0] select the home node |
| msg_valid_o | output | 1 | Outgoing message valid (registered) |
| msg_ready_i | input | 1 | Outgoing message taken |
| msg_kind_o | output | 2 | 0 invalidation, 1 intervention, 2 data reply, 3 reply without data |
| msg_dst_o | output | 2 | Destination node |
| msg_blk_o | output | 6 | Block address of the message |
| home_err_o | output | 1 | One-cycle pulse for a request homed at another node |

## Verification
Reads to uncached and shared blocks show that sharers accumulate. A read to an exclusive block must take the intervention-then-flush path instead of a direct reply. Write-class requests are tried against a sole holder and against several holders; this separates the immediate-reply path from the invalidate-and-count path and checks the target order and the absence of extra targets. Upgrades from a holder and from a non-holder tell apart replies with and without data. Foreign-home addresses, stray acknowledgements and flushes in idle, a request offered while acknowledgements are pending, and a stalled output port cover error, no-effect, serialization and hold behaviour.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [2:0] {
    IN_RD    = 3'd0,
    IN_RDX   = 3'd1,
    IN_UPG   = 3'd2,
    IN_IACK  = 3'd3,
    IN_FLUSH = 3'd4
  } in_kind_e;

  typedef enum logic [1:0] {
    OUT_INV    = 2'd0,
    OUT_INTV   = 2'd1,
    OUT_DATA   = 2'd2,
    OUT_NODATA = 2'd3
  } out_kind_e;

  typedef enum logic [1:0] {
    DS_UNC  = 2'b00,
    DS_SHR  = 2'b01,
    DS_EXC  = 2'b10,
    DS_BUSY = 2'b11
  } dstate_e;

  typedef enum logic [1:0] {
    ACT_REPLY = 2'd0,
    ACT_INV   = 2'd1,
    ACT_INTV  = 2'd2
  } act_e;
endpackage

// File: rtl/dir_store.sv
module dir_store #(
  parameter int ENTRIES = 16,
  parameter int DW      = 6,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i
);
  // plain array with registered read: maps to a simple dual-port RAM
  logic [DW-1:0] mem_q [ENTRIES];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_idx_i] <= wr_data_i;
    rd_q <= mem_q[rd_idx_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/dir_decide.sv
module dir_decide import dir_pkg::*; #(
  parameter int NODES   = 4,
  localparam int NODE_W = $clog2(NODES)
) (
  input  in_kind_e            kind_i,
  input  logic [NODE_W-1:0]   src_i,
  input  dstate_e             st_i,
  input  logic [NODES-1:0]    shr_i,
  output act_e                act_o,
  output logic [NODES-1:0]    inv_mask_o,
  output dstate_e             fin_st_o,
  output logic [NODES-1:0]    fin_shr_o,
  output out_kind_e           rep_o,
  output logic [NODE_W-1:0]   owner_o
);
  logic [NODES-1:0] req_bit;
  logic [NODES-1:0] others;
  logic             held;

  always_comb begin
    req_bit        = '0;
    req_bit[src_i] = 1'b1;
    others         = shr_i & ~req_bit;
    held           = (st_i == DS_SHR) || (st_i == DS_EXC);
    owner_o        = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (shr_i[i]) owner_o = NODE_W'(i);
    end

    act_o      = ACT_REPLY;
    inv_mask_o = '0;
    fin_st_o   = DS_EXC;
    fin_shr_o  = req_bit;
    rep_o      = OUT_DATA;

    if (kind_i == IN_RD) begin
      case (st_i)
        DS_EXC: begin
          if (shr_i[src_i]) begin
            fin_shr_o = shr_i;
          end else begin
            act_o     = ACT_INTV;
            fin_st_o  = DS_SHR;
            fin_shr_o = shr_i | req_bit;
          end
        end
        DS_SHR: begin
          fin_st_o  = DS_SHR;
          fin_shr_o = shr_i | req_bit;
        end
        default: begin
          fin_st_o  = DS_SHR;
          fin_shr_o = req_bit;
        end
      endcase
    end else begin
      if (held && (others != '0)) begin
        act_o      = ACT_INV;
        inv_mask_o = others;
      end
      if ((kind_i == IN_UPG) && held && shr_i[src_i]) rep_o = OUT_NODATA;
    end
  end

  // the requester is never a target of its own invalidations (R3)
  always_comb begin
    if (act_o == ACT_INV) begin
      p_no_self_inv_r3: assert (inv_mask_o[src_i] == 1'b0)
        else $error("invalidation aimed at requester");
    end
  end
endmodule

// File: rtl/dir_inv_seq.sv
module dir_inv_seq #(
  parameter int NODES   = 4,
  localparam int NODE_W = $clog2(NODES),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [NODES-1:0]  mask_i,
  input  logic              take_i,
  input  logic              ack_i,
  output logic              pend_o,
  output logic [NODE_W-1:0] pick_o,
  output logic              zero_o
);
  logic [NODES-1:0] mask_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ld_cnt;
  logic [NODES-1:0] pick_oh;

  always_comb begin
    ld_cnt = '0;
    for (int i = 0; i < NODES; i++) ld_cnt = ld_cnt + CNT_W'(mask_i[i]);
    pick_o  = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (mask_q[i]) pick_o = NODE_W'(i);
    end
    pick_oh         = '0;
    pick_oh[pick_o] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mask_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      mask_q <= mask_i;
      cnt_q  <= ld_cnt;
    end else begin
      if (take_i) mask_q <= mask_q & ~pick_oh;
      if (ack_i)  cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign pend_o = |mask_q;
  assign zero_o = (cnt_q == '0);

  // an issued invalidation always goes to a pending target (R3)
  p_take_pending_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    take_i |-> mask_q[pick_o]);
  // never more acknowledgements than invalidations (R4)
  p_ack_bound_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_i |-> (cnt_q != '0));
  // a new round starts only once the previous one has fully drained (R4)
  p_load_drained_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |-> (cnt_q == '0) && !(|mask_q));
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl import dir_pkg::*; #(
  parameter int NODES   = 4,
  parameter int BLK_W   = 6,
  parameter int HOME_ID = 1,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_kind_i,
  input  logic [NODE_W-1:0] req_src_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [1:0]        msg_kind_o,
  output logic [NODE_W-1:0] msg_dst_o,
  output logic [BLK_W-1:0]  msg_blk_o,
  output logic              home_err_o
);
  localparam int IDX_W   = BLK_W - NODE_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int DW      = 2 + NODES;

  typedef enum logic [2:0] {
    S_INIT, S_IDLE, S_LOOKUP, S_SEND_INV, S_WAIT_ACK, S_WAIT_FLUSH, S_REPLY
  } fsm_e;

  fsm_e              fsm_q;
  logic [IDX_W-1:0]  clr_q;
  in_kind_e          cur_kind_q;
  logic [NODE_W-1:0] cur_src_q, own_q;
  logic [BLK_W-1:0]  cur_blk_q;
  dstate_e           fin_st_q;
  logic [NODES-1:0]  fin_shr_q;
  out_kind_e         rep_q;
  logic              out_v_q, err_q;
  out_kind_e         out_k_q;
  logic [NODE_W-1:0] out_d_q;
  logic [BLK_W-1:0]  out_b_q;

  // directory storage
  logic             we;
  logic [IDX_W-1:0] wr_idx;
  logic [DW-1:0]    wr_data, rd_data;
  dstate_e          ent_st;
  logic [NODES-1:0] ent_shr;

  dir_store #(.ENTRIES(ENTRIES), .DW(DW)) u_store (
    .clk_i     (clk_i),
    .rd_idx_i  (req_blk_i[BLK_W-1:NODE_W]),
    .rd_data_o (rd_data),
    .we_i      (we),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data)
  );

  assign ent_st  = dstate_e'(rd_data[DW-1:NODES]);
  assign ent_shr = rd_data[NODES-1:0];

  // protocol decision for the request latched in the previous cycle
  act_e              dec_act;
  logic [NODES-1:0]  dec_inv, dec_fin_shr;
  dstate_e           dec_fin_st;
  out_kind_e         dec_rep;
  logic [NODE_W-1:0] dec_owner;

  dir_decide #(.NODES(NODES)) u_decide (
    .kind_i     (cur_kind_q),
    .src_i      (cur_src_q),
    .st_i       (ent_st),
    .shr_i      (ent_shr),
    .act_o      (dec_act),
    .inv_mask_o (dec_inv),
    .fin_st_o   (dec_fin_st),
    .fin_shr_o  (dec_fin_shr),
    .rep_o      (dec_rep),
    .owner_o    (dec_owner)
  );

  // invalidation issue order and acknowledgement count
  logic              seq_load, seq_take, seq_ack, seq_pend, seq_zero;
  logic [NODE_W-1:0] seq_pick;

  dir_inv_seq #(.NODES(NODES)) u_seq (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (seq_load),
    .mask_i (dec_inv),
    .take_i (seq_take),
    .ack_i  (seq_ack),
    .pend_o (seq_pend),
    .pick_o (seq_pick),
    .zero_o (seq_zero)
  );

  // handshake qualifiers
  logic is_req, home_ok, rdy, acc, out_free;

  assign is_req   = (req_kind_i == IN_RD) || (req_kind_i == IN_RDX) || (req_kind_i == IN_UPG);
  assign home_ok  = (req_blk_i[NODE_W-1:0] == NODE_W'(HOME_ID));
  assign out_free = !out_v_q || msg_ready_i;

  always_comb begin
    case (fsm_q)
      S_IDLE:                 rdy = !out_v_q;
      S_SEND_INV, S_WAIT_ACK: rdy = (req_kind_i == IN_IACK) && (req_blk_i == cur_blk_q) && !seq_zero;
      S_WAIT_FLUSH:           rdy = (req_kind_i == IN_FLUSH) && (req_blk_i == cur_blk_q) &&
                                    (req_src_i == own_q);
      default:                rdy = 1'b0;
    endcase
  end

  assign acc      = req_valid_i && rdy;
  assign seq_load = (fsm_q == S_LOOKUP) && (dec_act == ACT_INV);
  assign seq_take = (fsm_q == S_SEND_INV) && seq_pend && out_free;
  assign seq_ack  = acc && ((fsm_q == S_SEND_INV) || (fsm_q == S_WAIT_ACK));

  // directory write port: clear sweep, busy marking, final state
  always_comb begin
    we      = 1'b0;
    wr_idx  = cur_blk_q[BLK_W-1:NODE_W];
    wr_data = {fin_st_q, fin_shr_q};
    case (fsm_q)
      S_INIT: begin
        we      = 1'b1;
        wr_idx  = clr_q;
        wr_data = '0;
      end
      S_LOOKUP: begin
        we      = 1'b1;
        wr_data = (dec_act == ACT_REPLY) ? {dec_fin_st, dec_fin_shr} : {DS_BUSY, ent_shr};
      end
      S_REPLY: we = out_free;
      default: we = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fsm_q      <= S_INIT;
      clr_q      <= '0;
      cur_kind_q <= IN_RD;
      cur_src_q  <= '0;
      cur_blk_q  <= '0;
      own_q      <= '0;
      fin_st_q   <= DS_UNC;
      fin_shr_q  <= '0;
      rep_q      <= OUT_DATA;
      out_v_q    <= 1'b0;
      out_k_q    <= OUT_INV;
      out_d_q    <= '0;
      out_b_q    <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (out_free) out_v_q <= 1'b0;
      case (fsm_q)
        S_INIT: begin
          clr_q <= clr_q + 1'b1;
          if (clr_q == IDX_W'(ENTRIES - 1)) fsm_q <= S_IDLE;
        end
        S_IDLE: begin
          if (acc && is_req) begin
            if (home_ok) begin
              cur_kind_q <= in_kind_e'(req_kind_i);
              cur_src_q  <= req_src_i;
              cur_blk_q  <= req_blk_i;
              fsm_q      <= S_LOOKUP;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        S_LOOKUP: begin
          fin_st_q  <= dec_fin_st;
          fin_shr_q <= dec_fin_shr;
          rep_q     <= dec_rep;
          own_q     <= dec_owner;
          case (dec_act)
            ACT_REPLY: begin
              out_v_q <= 1'b1;
              out_k_q <= dec_rep;
              out_d_q <= cur_src_q;
              out_b_q <= cur_blk_q;
              fsm_q   <= S_IDLE;
            end
            ACT_INV: fsm_q <= S_SEND_INV;
            default: begin
              out_v_q <= 1'b1;
              out_k_q <= OUT_INTV;
              out_d_q <= dec_owner;
              out_b_q <= cur_blk_q;
              fsm_q   <= S_WAIT_FLUSH;
            end
          endcase
        end
        S_SEND_INV: begin
          if (seq_pend) begin
            if (out_free) begin
              out_v_q <= 1'b1;
              out_k_q <= OUT_INV;
              out_d_q <= seq_pick;
              out_b_q <= cur_blk_q;
            end
          end else begin
            fsm_q <= S_WAIT_ACK;
          end
        end
        S_WAIT_ACK:   if (seq_zero) fsm_q <= S_REPLY;
        S_WAIT_FLUSH: if (acc) fsm_q <= S_REPLY;
        S_REPLY: begin
          if (out_free) begin
            out_v_q <= 1'b1;
            out_k_q <= rep_q;
            out_d_q <= cur_src_q;
            out_b_q <= cur_blk_q;
            fsm_q   <= S_IDLE;
          end
        end
        default: fsm_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = rdy;
  assign msg_valid_o = out_v_q;
  assign msg_kind_o  = out_k_q;
  assign msg_dst_o   = out_d_q;
  assign msg_blk_o   = out_b_q;
  assign home_err_o  = err_q;

  // a foreign-home request never produces an outgoing message (R1)
  p_err_silent_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    err_q |-> !out_v_q);
  // the final reply waits for every acknowledgement (R4)
  p_reply_after_acks_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (fsm_q == S_REPLY) |-> seq_zero);
  // no new request enters while a transaction is open (R7)
  p_stall_open_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    ((fsm_q != S_IDLE) && is_req) |-> !req_ready_o);
  // nothing is accepted during the clearing sweep (R8)
  p_init_closed_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (fsm_q == S_INIT) |-> !req_ready_o && !out_v_q);
  // a stalled outgoing message is held unchanged (R9)
  p_out_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_v_q && !msg_ready_i) |=> out_v_q && $stable(out_k_q) && $stable(out_d_q) && $stable(out_b_q));
endmodule

// File: tb/sim_dir_home_ctrl.sv
`timescale 1ns/1ps
module sim_dir_home_ctrl;
  localparam int NODES = 4;
  localparam int BLK_W = 6;
  localparam int HOME  = 1;

  // kind codes used by the bench (R11, R2..R6)
  localparam logic [2:0] K_RD = 3'd0, K_RDX = 3'd1, K_UPG = 3'd2, K_ACK = 3'd3, K_FL = 3'd4;
  localparam int O_INV = 0, O_INTV = 1, O_DATA = 2, O_NOD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_kind  = '0;
  logic [1:0] req_src   = '0;
  logic [5:0] req_blk   = '0;
  logic       msg_valid;
  logic       msg_ready = 1'b1;
  logic [1:0] msg_kind, msg_dst;
  logic [5:0] msg_blk;
  logic       home_err;

  dir_home_ctrl #(.NODES(NODES), .BLK_W(BLK_W), .HOME_ID(HOME)) u0 (
    .clk_i (clk), .rst_i (rst),
    .req_valid_i (req_valid), .req_ready_o (req_ready),
    .req_kind_i (req_kind), .req_src_i (req_src), .req_blk_i (req_blk),
    .msg_valid_o (msg_valid), .msg_ready_i (msg_ready),
    .msg_kind_o (msg_kind), .msg_dst_o (msg_dst), .msg_blk_o (msg_blk),
    .home_err_o (home_err)
  );

  int checks = 0, fails = 0;
  int rx_n = 0, rx_rd = 0, err_n = 0;
  int rx_k [64];
  int rx_d [64];
  int rx_b [64];

  // record every transferred message and every error pulse, away from the edge
  always @(negedge clk) begin
    #1;
    if (msg_valid && msg_ready && rx_n < 64) begin
      rx_k[rx_n] = int'(msg_kind);
      rx_d[rx_n] = int'(msg_dst);
      rx_b[rx_n] = int'(msg_blk);
      rx_n++;
    end
    if (home_err) err_n++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [1:0] s, input logic [5:0] b, input string req);
    int t = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_src = s; req_blk = b;
    #1;
    while (!req_ready && t < 200) begin
      @(negedge clk); #1; t++;
    end
    if (!req_ready) chk(1'b0, req, "request never accepted", 0, 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic expect_msg(input string req, input int k, input int d, input int b);
    int t = 0;
    while (rx_n == rx_rd && t < 100) begin
      @(negedge clk); #2; t++;
    end
    if (rx_n == rx_rd) chk(1'b0, req, "missing message", -1, k * 10000 + d * 100 + b);
    else begin
      chk(rx_k[rx_rd] == k && rx_d[rx_rd] == d && rx_b[rx_rd] == b, req, "message kind*10000+dst*100+blk",
          rx_k[rx_rd] * 10000 + rx_d[rx_rd] * 100 + rx_b[rx_rd], k * 10000 + d * 100 + b);
      rx_rd++;
    end
  endtask

  task automatic expect_none(input string req, input int cyc);
    repeat (cyc) @(negedge clk);
    #2;
    chk(rx_n == rx_rd, req, "unexpected message count", rx_n - rx_rd, 0);
    rx_rd = rx_n;
  endtask

  // vector: [16:14] kind [13:12] src [11:6] blk [5:4] mode(0 msg,1 err,2 none) [3:2] out kind [1:0] dst
  localparam int NV = 11;
  localparam logic [16:0] VEC [NV] = '{
    {K_RD,  2'd0, 6'h05, 2'd0, 2'd2, 2'd0},  // R2 uncached read
    {K_RD,  2'd2, 6'h05, 2'd0, 2'd2, 2'd2},  // R2 shared read adds sharer
    {K_RDX, 2'd3, 6'h09, 2'd0, 2'd2, 2'd3},  // R5 write miss on uncached
    {K_UPG, 2'd3, 6'h09, 2'd0, 2'd3, 2'd3},  // R5 owner upgrade, no data
    {K_RD,  2'd1, 6'h0D, 2'd0, 2'd2, 2'd1},  // R2
    {K_UPG, 2'd1, 6'h0D, 2'd0, 2'd3, 2'd1},  // R5 sole sharer upgrade
    {K_RD,  2'd2, 6'h06, 2'd1, 2'd0, 2'd0},  // R1 home 2
    {K_RDX, 2'd0, 6'h3F, 2'd1, 2'd0, 2'd0},  // R1 home 3
    {K_ACK, 2'd0, 6'h05, 2'd2, 2'd0, 2'd0},  // R10 stray ack
    {K_FL,  2'd2, 6'h09, 2'd2, 2'd0, 2'd0},  // R10 stray flush
    {K_RDX, 2'd0, 6'h11, 2'd0, 2'd2, 2'd0}   // R5 write miss
  };

  function automatic string row_req(input int i);
    case (i)
      0, 1, 4:     return "R2";
      6, 7:        return "R1";
      8, 9:        return "R10";
      default:     return "R5";
    endcase
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R8 reset and clearing sweep
    repeat (3) @(negedge clk);
    #1;
    chk(msg_valid == 1'b0, "R8", "msg_valid in reset", int'(msg_valid), 0);
    chk(home_err == 1'b0, "R8", "home_err in reset", int'(home_err), 0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk(req_ready == 1'b0, "R8", "ready during sweep", int'(req_ready), 0);
    repeat (20) @(negedge clk);
    #1 chk(req_ready == 1'b1, "R8", "ready after sweep", int'(req_ready), 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      int e0;
      v  = VEC[i];
      e0 = err_n;
      send(v[16:14], v[13:12], v[11:6], row_req(i));
      case (v[5:4])
        2'd0: expect_msg(row_req(i), int'(v[3:2]), int'(v[1:0]), int'(v[11:6]));
        2'd1: begin
          expect_none(row_req(i), 8);
          chk(err_n == e0 + 1, row_req(i), "error pulse cycles", err_n - e0, 1);
        end
        default: begin
          expect_none(row_req(i), 8);
          chk(err_n == e0, row_req(i), "error pulses", err_n - e0, 0);
        end
      endcase
    end

    // R3 R4 R7: write to 0x05 shared by nodes 0 and 2, requested by node 1
    send(K_RDX, 2'd1, 6'h05, "R3");
    expect_msg("R3", O_INV, 0, 6'h05);
    expect_msg("R3", O_INV, 2, 6'h05);
    expect_none("R4", 6);
    @(negedge clk);
    req_valid = 1'b1; req_kind = K_RD; req_src = 2'd3; req_blk = 6'h19;
    for (int c = 0; c < 3; c++) begin
      #1 chk(req_ready == 1'b0, "R7", "ready while open", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    send(K_ACK, 2'd2, 6'h05, "R4");
    expect_none("R4", 6);
    send(K_ACK, 2'd0, 6'h05, "R4");
    expect_msg("R4", O_DATA, 1, 6'h05);

    // R6: read by node 3 of 0x05 now exclusive to node 1
    send(K_RD, 2'd3, 6'h05, "R6");
    expect_msg("R6", O_INTV, 1, 6'h05);
    expect_none("R6", 6);
    send(K_FL, 2'd1, 6'h05, "R6");
    expect_msg("R6", O_DATA, 3, 6'h05);

    // R5: upgrade by sharer 3 with other sharer 1 -> one invalidation, reply without data
    send(K_UPG, 2'd3, 6'h05, "R5");
    expect_msg("R3", O_INV, 1, 6'h05);
    expect_none("R3", 4);
    send(K_ACK, 2'd1, 6'h05, "R4");
    expect_msg("R5", O_NOD, 3, 6'h05);

    // R5: upgrade by node 2 that holds no copy -> data reply
    send(K_UPG, 2'd2, 6'h05, "R5");
    expect_msg("R3", O_INV, 3, 6'h05);
    send(K_ACK, 2'd3, 6'h05, "R4");
    expect_msg("R5", O_DATA, 2, 6'h05);

    // R9: output stall holds the message
    @(negedge clk); msg_ready = 1'b0;
    send(K_RD, 2'd2, 6'h15, "R9");
    repeat (3) @(negedge clk);
    begin
      logic [9:0] snap;
      #1 snap = {msg_kind, msg_dst, msg_blk};
      chk(msg_valid == 1'b1, "R9", "valid under stall", int'(msg_valid), 1);
      @(negedge clk);
      #1 chk({msg_kind, msg_dst, msg_blk} == snap, "R9", "held message", int'({msg_kind, msg_dst, msg_blk}), int'(snap));
    end
    msg_ready = 1'b1;
    expect_msg("R9", O_DATA, 2, 6'h15);

    finish_run();
  end
endmodule